// File: doc/BRIEF.md
# Status Event Recorder with Edge Filters

This block turns live instrument status lines into events that software can collect. Two register groups are built from the same logic. One group records operation status: calibrating, waiting for trigger, voltage regulation, and current regulation in either direction. The other group records questionable status: overvoltage, overcurrent, blown fuse, overtemperature, remote inhibit, loss of regulation, and measurement overload.

Each group samples its 16 condition lines once per clock. Each bit then passes through a rising-edge filter and a falling-edge filter. A transition that passes a filter is held in a sticky event register until software reads that register. Reading it also clears it. An enable mask selects which event bits count towards the group summary. The operation summary sets bit 7 of an 8-bit status byte and the questionable summary sets bit 3. Two external summaries also feed the status byte: message available and standard event.

Software uses a 4-bit register port. Address bit 3 selects the group: 0 for operation, 1 for questionable. Bits 2:0 select the register. Read data is combinational from the address. A write takes effect at the clock edge where `reg_we_i` is high. The event register clears at the clock edge where `reg_re_i` is high and the event register of that group is addressed.

Top module: `stat_report_top`

## Requirements
- R1: After reset, in both groups, the rising filter reads 16'hFFFF, and the falling filter, enable mask, condition and event registers each read 16'h0000.
- R2: The condition register (index 0) reads the condition inputs that were sampled at the most recent clock edge.
- R3: An event bit is set when its condition bit goes from 0 to 1 between two samples and the same bit of the rising filter (index 2) is 1. When that filter bit is 0, the rise sets nothing.
- R4: An event bit is set when its condition bit goes from 1 to 0 between two samples and the same bit of the falling filter (index 3) is 1. When that filter bit is 0, the fall sets nothing.
- R5: Event bits (index 1) stay set across any number of cycles until the event register of their group is read with `reg_re_i` high.
- R6: Reading the event register returns its current value, and the register is cleared at that clock edge. A transition that passes a filter at the same edge stays set after the clear.
- R7: A group summary is 1 exactly when some event bit is set and the same bit of the enable mask (index 4) is 1. The operation summary appears on status byte bit 7 and the questionable summary on bit 3.
- R8: Status byte bit 4 follows `mav_i` and bit 5 follows `esb_i`. Bit 6 is the OR of bits 3, 4, 5 and 7. Bits 2:0 read 0. Index 7 in either group returns the status byte in the low 8 bits of the read data.
- R9: The rising filter, falling filter and enable mask read back the value last written to them. Writes to the condition and event registers, and to unused indices, have no effect. Unused indices (5 and 6) read 0.
- R10: A write, read or clear that addresses one group leaves the registers and summary of the other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| oper_cond_i | input | 16 | Live operation condition lines |
| ques_cond_i | input | 16 | Live questionable condition lines |
| mav_i | input | 1 | Message-available summary for status byte bit 4 |
| esb_i | input | 1 | Standard-event summary for status byte bit 5 |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; clears the event register when it is addressed |
| reg_addr_i | input | 4 | Bit 3 selects the group; bits 2:0 select the register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for `reg_addr_i` |
| oper_sum_o | output | 1 | Operation group summary |
| ques_sum_o | output | 1 | Questionable group summary |
| stat_byte_o | output | 8 | Status byte |

## Verification
Condition samples, event bits and filter writes all become visible one clock edge after the inputs are driven. Read data, the summaries and the status byte follow the registers combinationally in that same cycle. The bench drives all inputs on the falling clock edge and compares read data for the addressed register shortly afterwards, before the rising edge can act on the read. It then advances its model at the rising edge and checks the summaries and the status byte at the next falling edge. The same-edge read-clear and new-transition case is checked at that falling edge through an event register read.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned STAT_W     = 16;
  localparam int unsigned STAT_IDX_W = 3;
  localparam int unsigned STAT_NGRP  = 2;
  localparam int unsigned SBYTE_W    = 8;

  typedef enum logic [STAT_IDX_W-1:0] {
    IDX_COND  = 3'd0,
    IDX_EVENT = 3'd1,
    IDX_RISE  = 3'd2,
    IDX_FALL  = 3'd3,
    IDX_MASK  = 3'd4,
    IDX_SBYTE = 3'd7
  } stat_idx_e;

  localparam int unsigned GRP_OPER = 0;
  localparam int unsigned GRP_QUES = 1;

  // status byte positions
  localparam int unsigned SB_QUES = 3;
  localparam int unsigned SB_MAV  = 4;
  localparam int unsigned SB_ESB  = 5;
  localparam int unsigned SB_MSS  = 6;
  localparam int unsigned SB_OPER = 7;

  // operation condition positions
  localparam int unsigned OP_CALIBRATING = 0;
  localparam int unsigned OP_TRIG_WAIT   = 5;
  localparam int unsigned OP_VOLT_REG    = 8;
  localparam int unsigned OP_CURR_POS    = 10;
  localparam int unsigned OP_CURR_NEG    = 11;

  // questionable condition positions
  localparam int unsigned QU_OVER_VOLT   = 0;
  localparam int unsigned QU_OVER_CURR   = 1;
  localparam int unsigned QU_FUSE_OPEN   = 2;
  localparam int unsigned QU_OVER_TEMP   = 4;
  localparam int unsigned QU_INHIBIT     = 9;
  localparam int unsigned QU_UNREG       = 10;
  localparam int unsigned QU_MEAS_OVLD   = 14;
endpackage

// File: rtl/stat_trans_detect.sv
module stat_trans_detect #(
  parameter int unsigned W = stat_pkg::STAT_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] hit_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic up, dn;
    assign up       = cur_i[b] & ~prev_i[b];
    assign dn       = ~cur_i[b] & prev_i[b];
    assign hit_o[b] = (up & rise_en_i[b]) | (dn & fall_en_i[b]);
  end
endmodule

// File: rtl/stat_group.sv
module stat_group #(
  parameter int unsigned W = stat_pkg::STAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic         we_rise_i,
  input  logic         we_fall_i,
  input  logic         we_mask_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] mask_o,
  output logic         sum_o
);
  logic [W-1:0] cond_q, ev_q, rise_q, fall_q, mask_q, hit;

  stat_trans_detect #(.W(W)) u_det (
    .cur_i    (cond_i),
    .prev_i   (cond_q),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .hit_o    (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      ev_q   <= '0;
      rise_q <= '1;
      fall_q <= '0;
      mask_q <= '0;
    end else begin
      cond_q <= cond_i;
      // new hits win over a same-edge clear
      ev_q   <= (clr_i ? '0 : ev_q) | hit;
      if (we_rise_i) rise_q <= wdata_i;
      if (we_fall_i) fall_q <= wdata_i;
      if (we_mask_i) mask_q <= wdata_i;
    end
  end

  assign cond_o = cond_q;
  assign ev_o   = ev_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign mask_o = mask_q;
  assign sum_o  = |(ev_q & mask_q);
endmodule

// File: rtl/stat_status_byte.sv
module stat_status_byte
  import stat_pkg::*;
(
  input  logic               oper_sum_i,
  input  logic               ques_sum_i,
  input  logic               mav_i,
  input  logic               esb_i,
  output logic [SBYTE_W-1:0] byte_o
);
  always_comb begin
    byte_o          = '0;
    byte_o[SB_OPER] = oper_sum_i;
    byte_o[SB_QUES] = ques_sum_i;
    byte_o[SB_MAV]  = mav_i;
    byte_o[SB_ESB]  = esb_i;
    byte_o[SB_MSS]  = oper_sum_i | ques_sum_i | mav_i | esb_i;
  end
endmodule

// File: rtl/stat_report_top.sv
module stat_report_top
  import stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        oper_cond_i,
  input  logic [W-1:0]        ques_cond_i,
  input  logic                mav_i,
  input  logic                esb_i,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [STAT_IDX_W:0] reg_addr_i,
  input  logic [W-1:0]        reg_wdata_i,
  output logic [W-1:0]        reg_rdata_o,
  output logic                oper_sum_o,
  output logic                ques_sum_o,
  output logic [SBYTE_W-1:0]  stat_byte_o
);
  localparam int unsigned NG = STAT_NGRP;

  logic [STAT_IDX_W-1:0] idx;
  logic                  grp;
  logic [W-1:0] g_cond_in [NG];
  logic [W-1:0] g_cond [NG];
  logic [W-1:0] g_ev   [NG];
  logic [W-1:0] g_rise [NG];
  logic [W-1:0] g_fall [NG];
  logic [W-1:0] g_mask [NG];
  logic [NG-1:0] g_sum;

  assign idx = reg_addr_i[STAT_IDX_W-1:0];
  assign grp = reg_addr_i[STAT_IDX_W];
  assign g_cond_in[GRP_OPER] = oper_cond_i;
  assign g_cond_in[GRP_QUES] = ques_cond_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic hit_grp;
    assign hit_grp = (grp == 1'(g));
    stat_group #(.W(W)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cond_i   (g_cond_in[g]),
      .we_rise_i(reg_we_i && hit_grp && idx == IDX_RISE),
      .we_fall_i(reg_we_i && hit_grp && idx == IDX_FALL),
      .we_mask_i(reg_we_i && hit_grp && idx == IDX_MASK),
      .wdata_i  (reg_wdata_i),
      .clr_i    (reg_re_i && hit_grp && idx == IDX_EVENT),
      .cond_o   (g_cond[g]),
      .ev_o     (g_ev[g]),
      .rise_o   (g_rise[g]),
      .fall_o   (g_fall[g]),
      .mask_o   (g_mask[g]),
      .sum_o    (g_sum[g])
    );
  end

  stat_status_byte u_sbyte (
    .oper_sum_i(g_sum[GRP_OPER]),
    .ques_sum_i(g_sum[GRP_QUES]),
    .mav_i     (mav_i),
    .esb_i     (esb_i),
    .byte_o    (stat_byte_o)
  );

  assign oper_sum_o = g_sum[GRP_OPER];
  assign ques_sum_o = g_sum[GRP_QUES];

  always_comb begin
    reg_rdata_o = '0;
    case (idx)
      IDX_COND:  reg_rdata_o = g_cond[grp];
      IDX_EVENT: reg_rdata_o = g_ev[grp];
      IDX_RISE:  reg_rdata_o = g_rise[grp];
      IDX_FALL:  reg_rdata_o = g_fall[grp];
      IDX_MASK:  reg_rdata_o = g_mask[grp];
      IDX_SBYTE: reg_rdata_o = W'(stat_byte_o);
      default:   reg_rdata_o = '0;
    endcase
  end

  // named taps for the bound checker
  logic [W-1:0] oper_cond_w, oper_ev_w, oper_rise_w, oper_fall_w, ques_ev_w;
  assign oper_cond_w = g_cond[GRP_OPER];
  assign oper_ev_w   = g_ev[GRP_OPER];
  assign oper_rise_w = g_rise[GRP_OPER];
  assign oper_fall_w = g_fall[GRP_OPER];
  assign ques_ev_w   = g_ev[GRP_QUES];
endmodule

// File: rtl/stat_report_chk.sv
module stat_report_chk
  import stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [W-1:0]        oper_cond_i,
  input logic                reg_re_i,
  input logic [STAT_IDX_W:0] reg_addr_i,
  input logic [W-1:0]        oper_cond_q,
  input logic [W-1:0]        oper_ev,
  input logic [W-1:0]        oper_rise,
  input logic [W-1:0]        oper_fall,
  input logic [W-1:0]        ques_ev
);
  logic oper_clr, ques_clr;
  logic [W-1:0] oper_up, oper_dn;

  assign oper_clr = reg_re_i && reg_addr_i == {1'b0, IDX_EVENT};
  assign ques_clr = reg_re_i && reg_addr_i == {1'b1, IDX_EVENT};
  assign oper_up  = oper_cond_i & ~oper_cond_q & oper_rise;
  assign oper_dn  = ~oper_cond_i & oper_cond_q & oper_fall;

  AST_COND_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (oper_cond_q == $past(oper_cond_i))); // R2
  AST_RISE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oper_up != '0) |=> ((oper_ev & $past(oper_up)) == $past(oper_up))); // R3
  AST_FALL_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oper_dn != '0) |=> ((oper_ev & $past(oper_dn)) == $past(oper_dn))); // R4
  AST_OPER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oper_clr |=> ((~oper_ev & $past(oper_ev)) == '0)); // R5
  AST_QUES_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ques_clr |=> ((~ques_ev & $past(ques_ev)) == '0)); // R10
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oper_clr |=> ((oper_ev & ~$past(oper_up | oper_dn)) == '0)); // R6
endmodule

bind stat_report_top stat_report_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oper_cond_i(oper_cond_i),
  .reg_re_i   (reg_re_i),
  .reg_addr_i (reg_addr_i),
  .oper_cond_q(oper_cond_w),
  .oper_ev    (oper_ev_w),
  .oper_rise  (oper_rise_w),
  .oper_fall  (oper_fall_w),
  .ques_ev    (ques_ev_w)
);

// File: tb/tb_stat_report_top.sv
module tb_stat_report_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] oper_cond_i = '0, ques_cond_i = '0;
  logic        mav_i = 1'b0, esb_i = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        oper_sum_o, ques_sum_o;
  logic [7:0]  stat_byte_o;

  stat_report_top dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_cond [2], m_ev [2], m_rise [2], m_fall [2], m_mask [2];

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_byte();
    logic [7:0] sb = '0;
    sb[7] = |(m_ev[0] & m_mask[0]);
    sb[3] = |(m_ev[1] & m_mask[1]);
    sb[4] = mav_i;
    sb[5] = esb_i;
    sb[6] = sb[7] | sb[3] | sb[4] | sb[5];
    return sb;
  endfunction

  function automatic logic [15:0] m_read(input logic [3:0] a);
    int g = a[3];
    case (a[2:0])
      3'd0: return m_cond[g];
      3'd1: return m_ev[g];
      3'd2: return m_rise[g];
      3'd3: return m_fall[g];
      3'd4: return m_mask[g];
      3'd7: return {8'h00, m_byte()};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a[2:0])
      3'd0: return "R2";
      3'd1: return "R5";
      3'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic m_reset();
    for (int g = 0; g < 2; g++) begin
      m_cond[g] = '0; m_ev[g] = '0; m_rise[g] = '1; m_fall[g] = '0; m_mask[g] = '0;
    end
  endtask

  task automatic m_step(input logic we, input logic re, input logic [3:0] a, input logic [15:0] wd);
    for (int g = 0; g < 2; g++) begin
      logic [15:0] c = (g == 0) ? oper_cond_i : ques_cond_i;
      logic [15:0] hit = (c & ~m_cond[g] & m_rise[g]) | (~c & m_cond[g] & m_fall[g]);
      logic sel = (a[3] == g[0]);
      m_ev[g]   = ((re && sel && a[2:0] == 3'd1) ? 16'h0 : m_ev[g]) | hit;
      m_cond[g] = c;
      if (we && sel && a[2:0] == 3'd2) m_rise[g] = wd;
      if (we && sel && a[2:0] == 3'd3) m_fall[g] = wd;
      if (we && sel && a[2:0] == 3'd4) m_mask[g] = wd;
    end
  endtask

  // called at a falling edge
  task automatic tick(input logic we, input logic re, input logic [3:0] a, input logic [15:0] wd, input string tag);
    reg_we_i = we; reg_re_i = re; reg_addr_i = a; reg_wdata_i = wd;
    #1;
    chk(tag, {"rdata ", rd_tag(a)}, reg_rdata_o, m_read(a));
    @(posedge clk_i);
    m_step(we, re, a, wd);
    @(negedge clk_i);
    reg_we_i = 0; reg_re_i = 0;
    chk(tag, "oper_sum R7", {15'h0, oper_sum_o}, {15'h0, |(m_ev[0] & m_mask[0])});
    chk(tag, "ques_sum R7", {15'h0, ques_sum_o}, {15'h0, |(m_ev[1] & m_mask[1])});
    chk(tag, "sbyte R8", {8'h0, stat_byte_o}, {8'h0, m_byte()});
  endtask

  task automatic peek(input logic [3:0] a, input logic [15:0] exp, input string tag);
    reg_addr_i = a; reg_we_i = 0; reg_re_i = 0;
    #1;
    chk(tag, "peek", reg_rdata_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values, both groups
    peek(4'h2, 16'hFFFF, "R1"); peek(4'hA, 16'hFFFF, "R1");
    peek(4'h3, 16'h0000, "R1"); peek(4'h4, 16'h0000, "R1");
    peek(4'h1, 16'h0000, "R1"); peek(4'h9, 16'h0000, "R1");
    peek(4'h0, 16'h0000, "R1"); peek(4'hC, 16'h0000, "R1");

    // R3 rise with default rising filter
    oper_cond_i = 16'h0020;
    tick(0, 0, 4'h0, 0, "R2");
    peek(4'h0, 16'h0020, "R2");
    peek(4'h1, 16'h0020, "R3");
    tick(0, 1, 4'h1, 0, "R6");
    peek(4'h1, 16'h0000, "R6");

    // R3 rise blocked by cleared filter
    tick(1, 0, 4'h2, 16'h0000, "R9");
    peek(4'h2, 16'h0000, "R9");
    oper_cond_i = 16'h0022;
    tick(0, 0, 4'h0, 0, "R3");
    peek(4'h1, 16'h0000, "R3");

    // R4 fall blocked, then passed
    oper_cond_i = 16'h0002;
    tick(0, 0, 4'h0, 0, "R4");
    peek(4'h1, 16'h0000, "R4");
    tick(1, 0, 4'h3, 16'h0002, "R9");
    oper_cond_i = 16'h0000;
    tick(0, 0, 4'h0, 0, "R4");
    peek(4'h1, 16'h0002, "R4");

    // R5 sticky
    for (int i = 0; i < 5; i++) tick(0, 0, 4'h3, 0, "R5");
    peek(4'h1, 16'h0002, "R5");

    // R7 summary on byte bit 7
    tick(1, 0, 4'h4, 16'h0002, "R7");
    chk("R7", "oper_sum", {15'h0, oper_sum_o}, 16'h0001);
    chk("R7", "sbyte", {8'h0, stat_byte_o}, 16'h00C0);

    // R6 clear with new rise on the same edge
    tick(1, 0, 4'h2, 16'hFFFF, "R9");
    oper_cond_i = 16'h0100;
    tick(0, 1, 4'h1, 0, "R6");
    peek(4'h1, 16'h0100, "R6");

    // R8 external summaries
    mav_i = 1;
    tick(0, 0, 4'h7, 0, "R8");
    chk("R8", "sbyte", {8'h0, stat_byte_o}, 16'h0050);
    esb_i = 1; mav_i = 0;
    tick(0, 0, 4'hF, 0, "R8");
    peek(4'hF, 16'h0060, "R8");
    esb_i = 0;

    // R9 writes to read-only and unused indices ignored
    tick(1, 0, 4'h0, 16'hFFFF, "R9");
    tick(1, 0, 4'h1, 16'hFFFF, "R9");
    tick(1, 0, 4'h5, 16'hFFFF, "R9");
    peek(4'h0, 16'h0100, "R9");
    peek(4'h1, 16'h0100, "R9");
    peek(4'h5, 16'h0000, "R9");

    // R10 questionable group independent
    ques_cond_i = 16'h0001;
    tick(1, 0, 4'hC, 16'h0001, "R10");
    chk("R10", "ques_sum", {15'h0, ques_sum_o}, 16'h0001);
    chk("R10", "sbyte", {8'h0, stat_byte_o}, 16'h0048);
    peek(4'h1, 16'h0100, "R10");
    tick(0, 1, 4'h9, 0, "R10");
    peek(4'h1, 16'h0100, "R10");
    peek(4'h9, 16'h0000, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] < 4) oper_cond_i = oper_cond_i ^ (16'h1 << r[7:4]);
      if (r[11:8] < 4) ques_cond_i = $urandom;
      mav_i = r[12]; esb_i = r[13] & r[14];
      tick(r[17:16] == 0, r[19:18] == 0, r[23:20], {r[31:24], r[31:24] ^ r[7:0]}, "rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule